// File: doc/BRIEF.md
# Dynamic VID Reference Controller

This block sits between a processor's voltage-identification (VID) pins and the DAC that sets a buck regulator's reference. It produces a reference code whose LSB is one 12.5 mV step. A sample grid derived from the phase-cycle strobe reads the VID bus several times per switching cycle. A new code is taken only after consecutive samples agree on it and it differs from the code in effect. A VID decoder outside the block supplies the numeric target code for the current bus value.

The mode input selects how an accepted code reaches the output. In single-step mode the requester moves one step at a time, so the reference jumps straight to the new target. In multi-step mode the request may span many steps. The block waits half a switching cycle, makes the first step, and then slews one LSB per phase strobe in either direction until the reference equals the target. If a new code is accepted during a slew, the target is replaced and the slew carries on from where it is.

Top module: `dvid_ref_ctrl`

## Requirements
- R1: While reset is low, the reference loads the decoded target of the present VID bus with no ramp, and busy is cleared, including when reset arrives in the middle of a ramp.
- R2: The VID bus is sampled every SPACING clocks, six times per switching cycle, and the grid restarts on every phase strobe. A change applied one clock after a strobe edge is accepted on the 6th rising edge (AGREE × SPACING). A change applied two clocks after the strobe edge is accepted on the 5th.
- R3: A new bus value held for fewer than three consecutive samples is ignored, as is a bus that changes on every sample: the reference and busy do not move.
- R4: In single-step mode (mode_multi = 0), the reference equals the new target on the clock edge that accepts it, and busy stays low.
- R5: In multi-step mode (mode_multi = 1), the reference holds its value for HALF = CYCLE/2 clocks after acceptance.
- R6: In multi-step mode, the first step is one LSB toward the target exactly HALF clocks after acceptance. Each further step is one LSB, on each phase strobe, upward or downward as the target requires.
- R7: busy rises on the accepting edge in multi-step mode and falls on the edge where the reference reaches the target. After that the reference holds.
- R8: A different code accepted during a ramp replaces the target with no second half-cycle wait. The next step falls on the next phase strobe and heads toward the new target, reversing direction if needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_stb | input | 1 | One-clock pulse at the start of each switching cycle |
| vid_bus | input | VID_W | Raw VID bus from the processor |
| mode_multi | input | 1 | 0: jump to an accepted code; 1: ramp one LSB per cycle |
| target_code | input | CODE_W | Decoded reference code for the current vid_bus |
| ref_code | output | CODE_W | Reference code to the DAC, one LSB per 12.5 mV |
| busy | output | 1 | High while the reference differs from the accepted target |

## Verification
The hardest case to reach is a retarget during a ramp that tells a continued ramp apart from one that restarts its half-cycle wait. With default timing, a restarted wait would step on exactly the same edge as a correct design. The stimulus locks onto the phase strobe and lets three upward steps complete. It then changes the code four clocks after a strobe, so acceptance lands two clocks before the next strobe. A restarted wait would move the output off the strobe and in the wrong cycle. The bench computes the expected reference for every clock of that window from the step arithmetic.

// File: rtl/dvid_pkg.sv
package dvid_pkg;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_WAIT = 2'd1,
      RS_RAMP = 2'd2
   } ramp_state_e;

endpackage

// File: rtl/dvid_sample_timer.sv
// Sample grid: one tick per SPACING clocks, realigned by the phase strobe.
module dvid_sample_timer #(
   parameter int SPACING = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phase_stb,
   output logic sample_tick
);
   localparam int SW = (SPACING > 1) ? $clog2(SPACING) : 1;

   logic [SW-1:0] sp_q;

   assign sample_tick = phase_stb | (sp_q == SW'(SPACING - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)           sp_q <= '0;
      else if (sample_tick) sp_q <= '0;
      else                  sp_q <= sp_q + 1'b1;
   end
endmodule

// File: rtl/dvid_code_filter.sv
// Debounce: accept pulses when AGREE consecutive samples match a new code.
module dvid_code_filter #(
   parameter int VID_W        = 6,
   parameter int AGREE        = 3,
   parameter int FILTER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_tick,
   input  logic [VID_W-1:0] vid_bus,
   output logic             accept
);
   logic [VID_W-1:0] held_q;
   logic             agreed;

   generate
      if (FILTER_STYLE == 0) begin : g_counter
         localparam int CW = $clog2(AGREE + 1);
         logic [VID_W-1:0] last_q;
         logic [CW-1:0]    run_q;
         logic             same;

         assign same   = (vid_bus == last_q);
         assign agreed = sample_tick && same && (run_q >= CW'(AGREE - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_q <= vid_bus;
               run_q  <= CW'(AGREE);
            end else if (sample_tick) begin
               if (!same) begin
                  last_q <= vid_bus;
                  run_q  <= CW'(1);
               end else if (run_q < CW'(AGREE)) begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end else begin : g_history
         localparam int HD = AGREE - 1;
         logic [VID_W-1:0] hist_q [HD];
         logic [HD-1:0]    eq;

         for (genvar i = 0; i < HD; i++) begin : g_cmp
            assign eq[i] = (hist_q[i] == vid_bus);
         end
         assign agreed = sample_tick && (&eq);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < HD; i++) hist_q[i] <= vid_bus;
            end else if (sample_tick) begin
               hist_q[0] <= vid_bus;
               for (int i = 1; i < HD; i++) hist_q[i] <= hist_q[i-1];
            end
         end
      end
   endgenerate

   assign accept = agreed && (vid_bus != held_q);

   always_ff @(posedge clk) begin
      if (!rst_n)      held_q <= vid_bus;
      else if (accept) held_q <= vid_bus;
   end
endmodule

// File: rtl/dvid_ref_slewer.sv
// Reference register: jump or ramp toward the accepted target.
module dvid_ref_slewer
   import dvid_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int HALF_CLKS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phase_stb,
   input  logic              accept,
   input  logic              mode_multi,
   input  logic [CODE_W-1:0] target_code,
   output logic [CODE_W-1:0] ref_code,
   output logic              busy
);
   localparam int WW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

   ramp_state_e       st_q, st_n;
   logic [WW-1:0]     wc_q, wc_n;
   logic [CODE_W-1:0] ref_q, ref_n, tgt_q, tgt_n;
   logic              busy_q, step;

   always_comb begin
      st_n  = st_q;
      wc_n  = wc_q;
      ref_n = ref_q;
      step  = 1'b0;
      tgt_n = accept ? target_code : tgt_q;
      if (accept && !mode_multi) begin
         ref_n = target_code;
         st_n  = RS_IDLE;
      end else begin
         unique case (st_q)
            RS_IDLE: begin
               if (accept) begin
                  st_n = RS_WAIT;
                  wc_n = WW'(HALF_CLKS - 1);
               end
            end
            RS_WAIT: begin
               if (wc_q == '0) begin
                  st_n = RS_RAMP;
                  step = 1'b1;
               end else begin
                  wc_n = wc_q - 1'b1;
               end
            end
            RS_RAMP: step = phase_stb;
            default: st_n = RS_IDLE;
         endcase
         if (step && (ref_q != tgt_n)) begin
            ref_n = (tgt_n > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
         end
         if (ref_n == tgt_n) st_n = RS_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RS_IDLE;
         wc_q   <= '0;
         ref_q  <= target_code;
         tgt_q  <= target_code;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         wc_q   <= wc_n;
         ref_q  <= ref_n;
         tgt_q  <= tgt_n;
         busy_q <= (ref_n != tgt_n);
      end
   end

   assign ref_code = ref_q;
   assign busy     = busy_q;
endmodule

// File: rtl/dvid_ref_ctrl.sv
module dvid_ref_ctrl #(
   parameter int VID_W        = 6,
   parameter int CODE_W       = 8,
   parameter int SAMPLES      = 6,
   parameter int SPACING      = 2,
   parameter int AGREE        = 3,
   parameter int FILTER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phase_stb,
   input  logic [VID_W-1:0]  vid_bus,
   input  logic              mode_multi,
   input  logic [CODE_W-1:0] target_code,
   output logic [CODE_W-1:0] ref_code,
   output logic              busy
);
   localparam int CYCLE_CLKS = SAMPLES * SPACING;
   localparam int HALF_CLKS  = CYCLE_CLKS / 2;

   if (AGREE < 2) begin : g_bad_agree
      $fatal(1, "AGREE must be at least 2");
   end
   if (CYCLE_CLKS < 2) begin : g_bad_cycle
      $fatal(1, "SAMPLES*SPACING must be at least 2");
   end
   if (CODE_W < 2 || VID_W < 1) begin : g_bad_width
      $fatal(1, "code and VID widths too small");
   end
   if (FILTER_STYLE != 0 && FILTER_STYLE != 1) begin : g_bad_style
      $fatal(1, "FILTER_STYLE must be 0 or 1");
   end

   logic sample_tick;
   logic accept;

   dvid_sample_timer #(.SPACING(SPACING)) i_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_stb   (phase_stb),
      .sample_tick (sample_tick)
   );

   dvid_code_filter #(
      .VID_W        (VID_W),
      .AGREE        (AGREE),
      .FILTER_STYLE (FILTER_STYLE)
   ) i_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_tick (sample_tick),
      .vid_bus     (vid_bus),
      .accept      (accept)
   );

   dvid_ref_slewer #(
      .CODE_W    (CODE_W),
      .HALF_CLKS (HALF_CLKS)
   ) i_slewer (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_stb   (phase_stb),
      .accept      (accept),
      .mode_multi  (mode_multi),
      .target_code (target_code),
      .ref_code    (ref_code),
      .busy        (busy)
   );
endmodule

// File: rtl/dvid_ref_ctrl_chk.sv
module dvid_ref_ctrl_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_multi,
   input logic              accept,
   input logic              busy,
   input logic [CODE_W-1:0] ref_code
);
   // R6: ramp moves are single LSB
   p_step_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_multi) && (ref_code != $past(ref_code)))
      |-> ((ref_code == $past(ref_code) + 1'b1) || (ref_code == $past(ref_code) - 1'b1)));

   // R5: idle in multi-step mode never moves the reference on acceptance
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_multi) && !$past(busy))
      |-> (ref_code == $past(ref_code)));

   // R4: single-step acceptance from idle leaves busy low
   p_single_no_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(mode_multi) && !$past(busy)) |-> !busy);

   // R7: without a new acceptance, busy only falls with a final step
   p_fall_on_arrival_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mode_multi) && !$past(accept) && $past(busy) && !busy)
      |-> (ref_code != $past(ref_code)));
endmodule

bind dvid_ref_ctrl dvid_ref_ctrl_chk #(.CODE_W(CODE_W)) i_dvid_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_multi (mode_multi),
   .accept     (accept),
   .busy       (busy),
   .ref_code   (ref_code)
);

// File: tb/test_dvid_ref_ctrl.sv
`timescale 1ns/1ps
module test_dvid_ref_ctrl;
   localparam int VID_W   = 6;
   localparam int CODE_W  = 8;
   localparam int SAMPLES = 6;
   localparam int SPACING = 2;
   localparam int AGREE   = 3;
   localparam int CYC     = SAMPLES * SPACING;
   localparam int HALF    = CYC / 2;
   localparam int LAT     = AGREE * SPACING;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              phase_stb = 1'b0;
   logic              mode_multi = 1'b0;
   logic [VID_W-1:0]  vid = 6'd5;
   logic [CODE_W-1:0] tgt;
   logic [CODE_W-1:0] ref_code;
   logic              busy;
   int n_chk = 0;
   int n_err = 0;
   int pcnt  = 0;

   function automatic int dec(input int v);
      return 40 + v;
   endfunction

   assign tgt = CODE_W'(dec(int'(vid)));

   always #4 clk = ~clk;

   always @(negedge clk) begin
      pcnt      <= (pcnt == CYC - 1) ? 0 : pcnt + 1;
      phase_stb <= (pcnt == CYC - 1);
   end

   dvid_ref_ctrl #(
      .VID_W(VID_W), .CODE_W(CODE_W), .SAMPLES(SAMPLES),
      .SPACING(SPACING), .AGREE(AGREE), .FILTER_STYLE(0)
   ) i_dvid_ref_ctrl (
      .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .vid_bus(vid),
      .mode_multi(mode_multi), .target_code(tgt),
      .ref_code(ref_code), .busy(busy)
   );

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // return at the negedge right after a strobe edge, plus off clocks
   task automatic align(input int off);
      do @(posedge clk); while (!phase_stb);
      @(negedge clk);
      repeat (off) @(negedge clk);
   endtask

   task automatic single_step(input int nv, input int off);
      int oldr = int'(ref_code);
      align(off);
      vid = VID_W'(nv);
      for (int p = 1; p <= LAT + 3; p++) begin
         @(posedge clk); @(negedge clk);
         chk_eq("R2/R4 jump timing", int'(ref_code), (p >= LAT - off) ? dec(nv) : oldr);
         chk_eq("R4 busy low", int'(busy), 0);
      end
   endtask

   task automatic ramp(input int nv);
      int oldr = int'(ref_code);
      int d    = dec(nv) - oldr;
      int n    = (d < 0) ? -d : d;
      int sg   = (d < 0) ? -1 : 1;
      int last = LAT + HALF + (n - 1) * CYC;
      align(0);
      vid = VID_W'(nv);
      for (int p = 1; p <= last + 14; p++) begin
         int st;
         @(posedge clk); @(negedge clk);
         st = (p < LAT + HALF) ? 0 : 1 + (p - LAT - HALF) / CYC;
         if (st > n) st = n;
         if (p < LAT + HALF) chk_eq("R5 hold during wait", int'(ref_code), oldr);
         else                chk_eq("R6 ramp value", int'(ref_code), oldr + sg * st);
         chk_eq("R7 busy window", int'(busy), (p >= LAT && p < last) ? 1 : 0);
      end
   endtask

   task automatic retarget();
      int v0 = int'(vid);
      int r0 = int'(ref_code);
      int sw = LAT + HALF + 2 * CYC + 4;
      int s2 = LAT + HALF + 3 * CYC;
      align(0);
      vid = VID_W'(v0 + 6);
      for (int p = 1; p <= s2 + 4 * CYC + 14; p++) begin
         int e;
         @(posedge clk); @(negedge clk);
         if (p < LAT + HALF) e = r0;
         else if (p < s2) e = r0 + 1 + (p - LAT - HALF) / CYC;
         else begin
            int k = 1 + (p - s2) / CYC;
            if (k > 5) k = 5;
            e = r0 + 3 - k;
         end
         chk_eq("R8 retarget path", int'(ref_code), e);
         chk_eq("R8 busy through retarget", int'(busy), (p >= LAT && p < s2 + 4 * CYC) ? 1 : 0);
         if (p == sw) vid = VID_W'(v0 - 2);
      end
   endtask

   task automatic glitches();
      int oldr = int'(ref_code);
      int v0   = int'(vid);
      align(1);
      vid = VID_W'(v0 + 1);
      for (int i = 0; i < (AGREE - 1) * SPACING + 2 * CYC; i++) begin
         @(negedge clk);
         if (i == (AGREE - 1) * SPACING - 1) vid = VID_W'(v0);
         chk_eq("R3 short pulse ignored", int'(ref_code), oldr);
         chk_eq("R3 busy stays low", int'(busy), 0);
      end
      align(0);
      for (int i = 0; i < 4 * CYC; i++) begin
         vid = VID_W'(v0 + 1 + ((i / SPACING) % 2));
         @(negedge clk);
         chk_eq("R3 toggling bus ignored", int'(ref_code), oldr);
      end
      vid = VID_W'(v0);
      repeat (2 * CYC) @(negedge clk);
      chk_eq("R3 value after toggling", int'(ref_code), oldr);
   endtask

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_eq("R1 reset ref", int'(ref_code), dec(5));
      chk_eq("R1 reset busy", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2 * CYC) @(negedge clk);
      chk_eq("R1 ref after release", int'(ref_code), dec(5));

      mode_multi = 1'b0;
      for (int v = 6; v <= 21; v++) single_step(v, v % 2);
      for (int v = 18; v >= 6; v -= 3) single_step(v, v % 2);
      glitches();

      mode_multi = 1'b1;
      ramp(10);
      ramp(9);
      ramp(15);
      ramp(10);
      ramp(12);
      glitches();
      retarget();

      align(0);
      vid = VID_W'(int'(vid) + 5);
      repeat (LAT + HALF + 4) @(negedge clk);
      chk_eq("R7 busy mid ramp", int'(busy), 1);
      rst_n = 1'b0;
      vid   = 6'd3;
      @(posedge clk); @(negedge clk);
      chk_eq("R1 reset during ramp ref", int'(ref_code), dec(3));
      chk_eq("R1 reset during ramp busy", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2 * CYC) @(negedge clk);
      chk_eq("R1 ref holds after reset", int'(ref_code), dec(3));

      summary();
      $finish;
   end
endmodule